// File: doc/BRIEF.md
# Programmable AND-plane evaluator

The block computes every product term of a 22V10-class programmable logic device. Its inputs are a flat fuse image, the dedicated clock pin, the eleven dedicated input pins and the ten feedback signals returned by the output cells. From these 22 signals it forms 44 literals, one true and one inverted copy of each. Each of the 132 rows then ANDs together the literals its fuses select.

The result is available in two forms. The first is a flat vector of all rows. The second is the rows regrouped into the global reset term, the global enable term, one term bank per output cell and a preset row per cell. The output cells downstream OR their own bank. The block is purely combinational.

Top module: `pld_and_plane`

## Requirements
- R1: Fuse `fuse_i[r*44 + c]` controls column `c` of row `r`. A 0 connects that literal to the row and a 1 leaves it out. Row `r` of `rows_o` is 1 exactly when every connected literal is 1.
- R2: Signal `s` drives column `2s` with its true value and column `2s+1` with its inverted value.
- R3: The true column of each signal is fixed:
  - `clk_pin_i` (pin 1) uses column 0.
  - `in_i[k]` for k = 0..9 is pin k+2 and uses column 4*(pin−1).
  - `in_i[10]` is pin 13 and uses column 42.
  - `fb_i[j]` is pin 23−j and uses column 94−4*pin, which equals 2+4j.
- R4: A row whose fuses are all 0 evaluates to 0.
- R5: A row whose fuses are all 1 evaluates to 1.
- R6: `ar_o` equals row 0 and `oe_o` equals row 1.
- R7: The term banks are laid out as follows:
  - Bank k (k = 0..9, serving feedback/pin index `fb_i[k]`) holds 8, 10, 12, 14, 16, 16, 14, 12, 10 or 8 terms.
  - The banks start at rows 2, 11, 22, 35, 50, 67, 84, 99, 112 and 123.
  - `bank_pt_o[k][t]` equals row base+t for t below the bank size. Higher bits of `bank_pt_o[k]` are 0.
  - `preset_o[k]` equals row base+size.
- R8: Every output follows its inputs combinationally, with no clock or state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fuse_i | input | 5808 | Fuse image, row-major, 44 columns per row |
| clk_pin_i | input | 1 | Dedicated clock pin as a logic signal |
| in_i | input | 11 | Dedicated inputs: bits 0..9 are pins 2..11, bit 10 is pin 13 |
| fb_i | input | 10 | Output-cell feedback, bit j from pin 23−j |
| rows_o | output | 132 | All product terms, bit r is row r |
| ar_o | output | 1 | Global asynchronous-reset term |
| oe_o | output | 1 | Global output-enable term |
| bank_pt_o | output | 10x16 | Product terms per output bank, unused high bits 0 |
| preset_o | output | 10 | Synchronous-preset row per bank |

## Verification
A wrong column mapping is hard to see from the ports. Random fuse images connect several literals per row, so one swapped column rarely changes the outputs. Directed vectors therefore connect a single true literal in one row and its complement in the next, for every pin in turn. The bench then toggles only that pin, which isolates each column. Random images are sparse, about one connection in sixteen fuses, so that rows take both values. These run alongside the all-open and all-shorted planes and the two-input AND case on the first bank.

// File: rtl/pld_plane_pkg.sv
package pld_plane_pkg;
  localparam int NUM_OUT = 10;
  localparam int NUM_DIN = 10;
  localparam int NUM_IN  = NUM_DIN + 1;
  localparam int NUM_SIG = 1 + NUM_IN + NUM_OUT;
  localparam int NUM_COL = 2 * NUM_SIG;
  localparam int MIN_PT  = 8;
  localparam int MAX_PT  = MIN_PT + 2 * ((NUM_OUT - 1) / 2);
  localparam int HDR_ROWS = 2;

  function automatic int bank_size(int k);
    int d;
    d = (k < NUM_OUT - 1 - k) ? k : NUM_OUT - 1 - k;
    return MIN_PT + 2 * d;
  endfunction

  function automatic int bank_base(int k);
    int b;
    b = HDR_ROWS;
    for (int i = 0; i < k; i++) b += bank_size(i) + 1;
    return b;
  endfunction

  localparam int NUM_ROW = bank_base(NUM_OUT);
  localparam int FUSE_W  = NUM_ROW * NUM_COL;
endpackage

// File: rtl/pld_literal_router.sv
module pld_literal_router
  import pld_plane_pkg::*;
(
  input  logic               clk_pin_i,
  input  logic [NUM_IN-1:0]  in_i,
  input  logic [NUM_OUT-1:0] fb_i,
  output logic [NUM_COL-1:0] lit_o
);
  logic [NUM_SIG-1:0] sig;

  // feedback and dedicated inputs interleave: fb j -> sig 1+2j, din k -> sig 2+2k
  always_comb begin
    sig = '0;
    sig[0] = clk_pin_i;
    for (int j = 0; j < NUM_OUT; j++) sig[1 + 2*j] = fb_i[j];
    for (int k = 0; k < NUM_DIN; k++) sig[2 + 2*k] = in_i[k];
    sig[NUM_SIG-1] = in_i[NUM_IN-1];
  end

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_pair
    assign lit_o[2*s]   = sig[s];
    assign lit_o[2*s+1] = ~sig[s];
  end

  always_comb begin
    for (int s = 0; s < NUM_SIG; s++)
      AST_LIT_PAIR: assert (lit_o[2*s] != lit_o[2*s+1]); // R2
  end
endmodule

// File: rtl/pld_and_row.sv
module pld_and_row
  import pld_plane_pkg::*;
(
  input  logic [NUM_COL-1:0] fuse_row_i,
  input  logic [NUM_COL-1:0] lit_i,
  output logic               term_o
);
  // blown fuse (1) forces its column high
  assign term_o = &(lit_i | fuse_row_i);

  always_comb begin
    if (&fuse_row_i)
      AST_OPEN_ROW: assert (term_o); // R5
    if (fuse_row_i == '0)
      AST_SHORT_ROW: assert (!term_o); // R4
    if (term_o)
      AST_NO_LOW_LIT: assert ((~lit_i & ~fuse_row_i) == '0); // R1
  end
endmodule

// File: rtl/pld_and_array.sv
module pld_and_array
  import pld_plane_pkg::*;
(
  input  logic [FUSE_W-1:0]  fuse_i,
  input  logic [NUM_COL-1:0] lit_i,
  output logic [NUM_ROW-1:0] rows_o
);
  for (genvar r = 0; r < NUM_ROW; r++) begin : g_row
    pld_and_row u_row (
      .fuse_row_i(fuse_i[r*NUM_COL +: NUM_COL]),
      .lit_i     (lit_i),
      .term_o    (rows_o[r])
    );
  end
endmodule

// File: rtl/pld_row_groups.sv
module pld_row_groups
  import pld_plane_pkg::*;
(
  input  logic [NUM_ROW-1:0]             rows_i,
  output logic                           ar_o,
  output logic                           oe_o,
  output logic [NUM_OUT-1:0][MAX_PT-1:0] bank_pt_o,
  output logic [NUM_OUT-1:0]             preset_o
);
  assign ar_o = rows_i[0];
  assign oe_o = rows_i[1];

  always_comb begin
    bank_pt_o = '0;
    preset_o  = '0;
    for (int k = 0; k < NUM_OUT; k++) begin
      for (int t = 0; t < MAX_PT; t++)
        if (t < bank_size(k)) bank_pt_o[k][t] = rows_i[bank_base(k) + t];
      preset_o[k] = rows_i[bank_base(k) + bank_size(k)];
    end
  end
endmodule

// File: rtl/pld_and_plane.sv
module pld_and_plane
  import pld_plane_pkg::*;
(
  input  logic [FUSE_W-1:0]              fuse_i,
  input  logic                           clk_pin_i,
  input  logic [NUM_IN-1:0]              in_i,
  input  logic [NUM_OUT-1:0]             fb_i,
  output logic [NUM_ROW-1:0]             rows_o,
  output logic                           ar_o,
  output logic                           oe_o,
  output logic [NUM_OUT-1:0][MAX_PT-1:0] bank_pt_o,
  output logic [NUM_OUT-1:0]             preset_o
);
  logic [NUM_COL-1:0] lit;

  pld_literal_router u_router (
    .clk_pin_i(clk_pin_i),
    .in_i     (in_i),
    .fb_i     (fb_i),
    .lit_o    (lit)
  );

  pld_and_array u_array (
    .fuse_i(fuse_i),
    .lit_i (lit),
    .rows_o(rows_o)
  );

  pld_row_groups u_groups (
    .rows_i   (rows_o),
    .ar_o     (ar_o),
    .oe_o     (oe_o),
    .bank_pt_o(bank_pt_o),
    .preset_o (preset_o)
  );

  localparam logic [NUM_COL-1:0] ONLY_COL0 = {{(NUM_COL-1){1'b1}}, 1'b0};

  always_comb begin
    if (fuse_i[0 +: NUM_COL] == ONLY_COL0)
      AST_AR_CLK_COL: assert (ar_o == clk_pin_i); // R3
    if (&fuse_i[NUM_COL +: NUM_COL])
      AST_OE_OPEN: assert (oe_o); // R6
  end
endmodule

// File: tb/pld_and_plane_tb.sv
module pld_and_plane_tb;
  localparam int NR = 132;
  localparam int NC = 44;
  localparam int FW = NR * NC;

  logic clk = 0;
  logic rst_ni = 0;
  always #2 clk = ~clk;

  logic [FW-1:0]    fuse;
  logic             clk_pin;
  logic [10:0]      din;
  logic [9:0]       fb;
  logic [NR-1:0]    rows;
  logic             ar, oe;
  logic [9:0][15:0] bank_pt;
  logic [9:0]       preset;

  pld_and_plane u_dut (
    .fuse_i(fuse), .clk_pin_i(clk_pin), .in_i(din), .fb_i(fb),
    .rows_o(rows), .ar_o(ar), .oe_o(oe), .bank_pt_o(bank_pt), .preset_o(preset)
  );

  int n_chk = 0;
  int n_fail = 0;
  int sizes [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
  int bases [10] = '{2, 11, 22, 35, 50, 67, 84, 99, 112, 123};

  function automatic int true_col(int p);
    if (p == 1) return 0;
    if (p >= 2 && p <= 11) return 4 * (p - 1);
    if (p == 13) return 42;
    return 94 - 4 * p;
  endfunction

  function automatic logic pin_val(int p);
    if (p == 1) return clk_pin;
    if (p >= 2 && p <= 11) return din[p-2];
    if (p == 13) return din[10];
    return fb[23-p];
  endfunction

  function automatic logic [NR-1:0] model_rows();
    logic [NC-1:0] lv;
    logic [NR-1:0] res;
    lv = '0;
    for (int p = 1; p <= 23; p++) begin
      if (p != 12) begin
        lv[true_col(p)]   = pin_val(p);
        lv[true_col(p)+1] = ~pin_val(p);
      end
    end
    for (int r = 0; r < NR; r++) begin
      res[r] = 1'b1;
      for (int c = 0; c < NC; c++)
        if (!fuse[r*NC+c] && !lv[c]) res[r] = 1'b0;
    end
    return res;
  endfunction

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [NR-1:0] e;
    logic [9:0][15:0] eb;
    logic [9:0] ep;
    e = model_rows();
    eb = '0;
    for (int k = 0; k < 10; k++) begin
      for (int t = 0; t < sizes[k]; t++) eb[k][t] = e[bases[k]+t];
      ep[k] = e[bases[k]+sizes[k]];
    end
    chk({tag, " R1 R8 rows"}, 256'(rows), 256'(e));
    chk({tag, " R6 ar"}, 256'(ar), 256'(e[0]));
    chk({tag, " R6 oe"}, 256'(oe), 256'(e[1]));
    chk({tag, " R7 banks"}, 256'(bank_pt), 256'(eb));
    chk({tag, " R7 preset"}, 256'(preset), 256'(ep));
  endtask

  task automatic set_pin(int p, logic v);
    if (p == 1) clk_pin = v;
    else if (p >= 2 && p <= 11) din[p-2] = v;
    else if (p == 13) din[10] = v;
    else fb[23-p] = v;
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    fuse = '0; clk_pin = 0; din = '0; fb = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1;
    settle();
    // R4: shorted plane gives all zero
    chk("R4 all-zero fuses", 256'(rows), 256'(0));
    check_all("R4 reset image");

    @(posedge clk); fuse = '1; din = 11'h5a3; fb = 10'h2c6;
    settle();
    chk("R5 all-one fuses", 256'(rows), 256'({NR{1'b1}}));
    check_all("R5 open plane");

    // R1: two-input AND on first bank
    for (int v = 0; v < 4; v++) begin
      @(posedge clk);
      fuse = '0;
      fuse[2*NC +: NC] = '1;
      fuse[92] = 1'b0;
      fuse[96] = 1'b0;
      din = '0; din[0] = v[0]; din[1] = v[1]; fb = '0; clk_pin = 0;
      settle();
      chk("R1 and-gate row2", 256'(rows[2]), 256'(v[0] & v[1]));
      chk("R4 rows3-9 zero", 256'(rows[9:3]), 256'(0));
      chk("R7 bank0 term0", 256'(bank_pt[0][0]), 256'(v[0] & v[1]));
    end

    // R2 R3: single literal per row, every pin
    for (int p = 1; p <= 23; p++) begin
      if (p != 12) begin
        for (int v = 0; v < 2; v++) begin
          @(posedge clk);
          fuse = '1;
          fuse[2*NC + true_col(p)] = 1'b0;
          fuse[3*NC + true_col(p) + 1] = 1'b0;
          din = 11'h7ff; fb = 10'h3ff; clk_pin = 1;
          set_pin(p, v[0]);
          settle();
          chk($sformatf("R3 pin%0d true col", p), 256'(rows[2]), 256'(v[0]));
          chk($sformatf("R2 pin%0d comp col", p), 256'(rows[3]), 256'(!v[0]));
        end
      end
    end

    // R3 R6: reset term from clock column
    for (int v = 0; v < 2; v++) begin
      @(posedge clk);
      fuse = '1; fuse[0] = 1'b0; clk_pin = v[0];
      settle();
      chk("R6 ar follows clk col", 256'(ar), 256'(v[0]));
      chk("R6 oe open", 256'(oe), 256'(1));
    end

    // random sparse images
    for (int n = 0; n < 120; n++) begin
      @(posedge clk);
      for (int i = 0; i < FW; i++) fuse[i] = ($urandom_range(0, 15) != 0);
      din = 11'($urandom); fb = 10'($urandom); clk_pin = 1'($urandom);
      settle();
      check_all("random");
      // R8: change inputs only, same fuses
      @(posedge clk);
      din = ~din; fb = 10'($urandom);
      settle();
      check_all("R8 input change");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule